// File: doc/BRIEF.md
# Gold Code Tracking Generator

This block produces one of the 1023-chip Gold spreading sequences and delivers it as a set of half-chip-spaced replicas for a correlator. A 25-bit numerically controlled oscillator runs on the sample clock. Each carry out of its accumulator is one half-chip step. The code therefore advances once for every two carries, so a nominal increment gives a 2.046 MHz half-chip rate and a 1.023 MHz chip rate.

The block drives two replica outputs. The prompt replica is always present. The tracking replica is selected by a 2-bit mode field and can be:
- the early copy,
- the late copy,
- a dithered copy that swaps between early and late every 20 code periods (20 ms at nominal rate), or
- the signed difference early minus late.

A one-cycle strobe marks the start of each code period. The 10-bit select pattern is captured only at that moment, so software may change it at any time and the switch takes effect cleanly on the next period.

Top module: `gold_code_gen`

## Requirements
- R1: The 25-bit accumulator adds `code_inc` on every clock. A carry out of bit 24 produces one half-chip step. Each chip lasts exactly two steps, so successive code periods are 2046 steps apart. With the maximum increment this is 2046 clocks; with `code_inc` = 2^24 it is 4092 clocks.
- R2: The code comes from two 10-bit registers (stage 1 is bit 0 and stage 10 is bit 9), shifted toward stage 10.
  - Register A has feedback stage 3 xor stage 10. Register B has feedback stages 2, 3, 6, 8, 9 and 10 xored.
  - At the start of every period, register A is loaded with all ones and register B with `code_sel`.
  - The chip bit is the xor of the two stage-10 bits.
- R3: The early replica carries the current chip. Prompt is the early value from one half-chip step earlier, and late is the early value from two steps earlier.
- R4: Chip bit 0 is output as +1 and chip bit 1 as -1, as two's complement values on `prompt_out` (2 bits) and `track_out` (3 bits).
- R5: With `trk_mode` = 00, `track_out` shows the early replica. With `trk_mode` = 01, it shows the late replica.
- R6: With `trk_mode` = 10, `track_out` shows early until 20 period starts have been counted since reset (the first period included), then late for the next 20, and so on alternately. The selection switches on the clock after the strobe.
- R7: With `trk_mode` = 11, `track_out` equals early minus late, which takes only the values -2, 0 or +2.
- R8: `epoch_out` is high for exactly one clock. That clock is the first one in which the early replica shows chip 0 of a period.
- R9: Changing `code_sel` in the middle of a period does not alter the current period. The new pattern governs the period that follows.
- R10: While reset is asserted, `prompt_out` and `track_out` are +1 and `epoch_out` is low. The first half-chip step after reset starts a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_inc | input | 25 | Code oscillator phase increment per clock |
| code_sel | input | 10 | Initial state of register B, i.e. the code choice |
| trk_mode | input | 2 | Tracking replica mode: 00 early, 01 late, 10 dithered, 11 early minus late |
| prompt_out | output | 2 | Prompt replica, signed ±1 |
| track_out | output | 3 | Tracking replica, signed ±1, or 0/±2 in difference mode |
| epoch_out | output | 1 | One-clock strobe at the start of each code period |

## Verification
The bench compares every replica against an independently computed chip sequence over a whole code period and across its wrap.

It targets four corner cases:
- **Prompt and late at the period boundary.** These must still show the last chip of the previous code. A design that restarted its delay line at the strobe would show the wrong value there.
- **Mid-period change of the select pattern.** A design that fed `code_sel` into register B while the period was running would corrupt the chips that follow.
- **Dither boundary.** The bench checks the 19th, 20th and 40th periods. An off-by-one period counter would switch one period early or late.
- **Half-rate increment.** This exposes a design that advanced the code on every carry instead of every second one.

// File: rtl/gcg_pkg.sv
package gcg_pkg;

  typedef enum logic [1:0] {
    TRK_EARLY  = 2'b00,
    TRK_LATE   = 2'b01,
    TRK_DITHER = 2'b10,
    TRK_DIFF   = 2'b11
  } trk_mode_e;

  // chip bit 0 -> +1, chip bit 1 -> -1
  function automatic logic signed [1:0] chip_bipolar(input logic c);
    return c ? -2'sd1 : 2'sd1;
  endfunction

endpackage

// File: rtl/gcg_nco.sv
module gcg_nco #(
  parameter int ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic             step
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             step_d;

  always_comb begin
    {step_d, acc_d} = {1'b0, acc_q} + {1'b0, inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      step  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      step  <= step_d;
    end
  end

  // R1: a carry leaves a residue below the increment; no carry leaves at least it
  p_carry_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && step) |-> (acc_q < $past(inc)));
  p_no_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !step) |-> (acc_q >= $past(inc)));

endmodule

// File: rtl/gcg_gold.sv
module gcg_gold #(
  parameter int CHIPS = 1023,
  parameter int SR_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [SR_W-1:0] sel,
  output logic            chip,
  output logic            epoch
);

  localparam int CNT_W = $clog2(CHIPS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS - 1);

  logic [SR_W-1:0]  ga_q, ga_d, gb_q, gb_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d, epoch_d;
  logic             fb_a, fb_b;

  assign fb_a = ga_q[2] ^ ga_q[9];
  assign fb_b = gb_q[1] ^ gb_q[2] ^ gb_q[5] ^ gb_q[7] ^ gb_q[8] ^ gb_q[9];
  assign chip = ga_q[SR_W-1] ^ gb_q[SR_W-1];

  always_comb begin
    ga_d    = ga_q;
    gb_d    = gb_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    epoch_d = 1'b0;
    if (step) begin
      half_d = ~half_q;
      if (half_q) begin
        if (cnt_q == LAST) begin
          ga_d    = '1;
          gb_d    = sel;
          cnt_d   = '0;
          epoch_d = 1'b1;
        end else begin
          ga_d  = {ga_q[SR_W-2:0], fb_a};
          gb_d  = {gb_q[SR_W-2:0], fb_b};
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ga_q   <= '1;
      gb_q   <= '1;
      cnt_q  <= LAST;
      half_q <= 1'b1;
      epoch  <= 1'b0;
    end else begin
      ga_q   <= ga_d;
      gb_q   <= gb_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      epoch  <= epoch_d;
    end
  end

  // R2: a period starts from all ones in A and the pattern seen at the load edge in B
  p_load_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |-> (ga_q == '1 && gb_q == $past(sel)));
  // R8: strobe lasts one clock
  p_epoch_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |=> !epoch);
  // R1: state only moves on a step
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(step)) |-> ($stable(ga_q) && $stable(half_q)));

endmodule

// File: rtl/gcg_replica.sv
module gcg_replica
  import gcg_pkg::*;
#(
  parameter int DWELL = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              epoch,
  input  logic              chip,
  input  logic [1:0]        mode,
  output logic signed [1:0] prompt,
  output logic signed [2:0] track
);

  localparam int DW_W = $clog2(DWELL);
  localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

  logic [1:0]        dly_q, dly_d;  // [0] prompt, [1] late
  logic [DW_W-1:0]   dw_q, dw_d;
  logic              dsel_q, dsel_d;
  logic signed [2:0] e_v, l_v;

  always_comb begin
    dly_d  = dly_q;
    dw_d   = dw_q;
    dsel_d = dsel_q;
    if (step) dly_d = {dly_q[0], chip};
    if (epoch) begin
      if (dw_q == DW_LAST) begin
        dw_d   = '0;
        dsel_d = ~dsel_q;
      end else begin
        dw_d = dw_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= '0;
      dw_q   <= '0;
      dsel_q <= 1'b0;
    end else begin
      dly_q  <= dly_d;
      dw_q   <= dw_d;
      dsel_q <= dsel_d;
    end
  end

  assign e_v    = chip_bipolar(chip);
  assign l_v    = chip_bipolar(dly_q[1]);
  assign prompt = chip_bipolar(dly_q[0]);

  always_comb begin
    unique case (trk_mode_e'(mode))
      TRK_EARLY:  track = e_v;
      TRK_LATE:   track = l_v;
      TRK_DITHER: track = dsel_q ? l_v : e_v;
      TRK_DIFF:   track = e_v - l_v;
      default:    track = e_v;
    endcase
  end

  // R3: prompt picks up the early bit present at the previous step
  p_prompt_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step)) |-> (dly_q[0] == $past(chip)));
  // R6: dither selection only moves right after a period start
  p_dither_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dsel_q) |-> $past(epoch));
  // R7: difference mode never yields an odd value; other modes always do
  p_diff_even_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (track[0] == 1'b0));
  p_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b11) |-> (track == 3'sd1 || track == -3'sd1));

endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen #(
  parameter int INC_W = 25,
  parameter int SEL_W = 10,
  parameter int CHIPS = 1023,
  parameter int DWELL = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  code_inc,
  input  logic [SEL_W-1:0]  code_sel,
  input  logic [1:0]        trk_mode,
  output logic signed [1:0] prompt_out,
  output logic signed [2:0] track_out,
  output logic              epoch_out
);

  logic step, chip, epoch;

  gcg_nco #(.ACC_W(INC_W)) u_nco (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (code_inc),
    .step (step)
  );

  gcg_gold #(.CHIPS(CHIPS), .SR_W(SEL_W)) u_gold (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .sel  (code_sel),
    .chip (chip),
    .epoch(epoch)
  );

  gcg_replica #(.DWELL(DWELL)) u_rep (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .epoch (epoch),
    .chip  (chip),
    .mode  (trk_mode),
    .prompt(prompt_out),
    .track (track_out)
  );

  assign epoch_out = epoch;

endmodule

// File: tb/sim_gold_code_gen.sv
module sim_gold_code_gen;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic [24:0]       inc;
  logic [9:0]        sel;
  logic [1:0]        mode;
  logic signed [1:0] prompt;
  logic signed [2:0] track;
  logic              epoch;

  gold_code_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_inc  (inc),
    .code_sel  (sel),
    .trk_mode  (mode),
    .prompt_out(prompt),
    .track_out (track),
    .epoch_out (epoch)
  );

  int checks = 0;
  int errors = 0;

  typedef logic chip_arr_t [0:1022];
  chip_arr_t cur_code, prv_code;

  localparam logic [24:0] INC_MAX  = 25'h1FFFFFF;
  localparam logic [24:0] INC_HALF = 25'h1000000;

  function automatic chip_arr_t make_code(input logic [9:0] s);
    chip_arr_t r;
    logic [9:0] a;
    logic [9:0] b;
    logic fa, fb;
    a = 10'h3FF;
    b = s;
    for (int i = 0; i < 1023; i++) begin
      r[i] = a[9] ^ b[9];
      fa = a[2] ^ a[9];
      fb = b[1] ^ b[2] ^ b[5] ^ b[7] ^ b[8] ^ b[9];
      a = {a[8:0], fa};
      b = {b[8:0], fb};
    end
    return r;
  endfunction

  function automatic logic signed [2:0] bip(input logic c);
    return c ? -3'sd1 : 3'sd1;
  endfunction

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [9:0] s, input logic [1:0] m, input logic [24:0] i);
    rst_n = 1'b0;
    sel   = s;
    mode  = m;
    inc   = i;
    repeat (3) @(negedge clk);
    chk("R10", "reset prompt", int'(prompt), 1);
    chk("R10", "reset track", int'(track), 1);
    chk("R10", "reset epoch", int'(epoch), 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_epoch;
    do @(negedge clk); while (epoch !== 1'b1);
  endtask

  // one step per clock; h counts clocks since the period strobe
  task automatic check_cycle(input int h);
    logic eb, pb, lb;
    eb = cur_code[h/2];
    pb = (h >= 1) ? cur_code[(h-1)/2] : prv_code[1022];
    lb = (h >= 2) ? cur_code[(h-2)/2] : prv_code[1022];
    chk("R8", "epoch strobe", int'(epoch), (h == 0) ? 1 : 0);
    chk("R3", "prompt", int'(prompt), int'(bip(pb)));
    mode = 2'b00; #1;
    chk("R5", "early", int'(track), int'(bip(eb)));
    mode = 2'b01; #1;
    chk("R5", "late", int'(track), int'(bip(lb)));
    mode = 2'b11; #1;
    chk("R7", "early minus late", int'(track), int'(bip(eb)) - int'(bip(lb)));
  endtask

  // R2 R3 R4 R9: full period, wrap, and a mid-period select change
  task automatic t_sequence;
    logic [9:0] sa, sb;
    sa = 10'b1100100000;
    sb = 10'b1110010000;
    for (int i = 0; i < 1023; i++) prv_code[i] = 1'b0;
    cur_code = make_code(sa);
    do_reset(sa, 2'b00, INC_MAX);
    wait_epoch();
    for (int h = 0; h < 2046; h++) begin
      if (h == 1000) sel = sb;
      check_cycle(h);
      @(negedge clk);
    end
    prv_code = cur_code;
    cur_code = make_code(sb);
    for (int h = 0; h < 120; h++) begin
      check_cycle(h);
      @(negedge clk);
    end
  endtask

  // R1: half-rate increment, chip lasts four clocks, period 4092 clocks
  task automatic t_rate;
    int cnt;
    cur_code = make_code(10'b1001011100);
    do_reset(10'b1001011100, 2'b00, INC_HALF);
    wait_epoch();
    for (int h = 0; h < 40; h++) begin
      chk("R1", "early at half rate", int'(track), int'(bip(cur_code[h/4])));
      @(negedge clk);
    end
    cnt = 40;
    while (epoch !== 1'b1) begin
      @(negedge clk);
      cnt++;
    end
    chk("R1", "period length at half rate", cnt, 4092);
  endtask

  // R6: dithered selection around the 20th and 40th period
  task automatic t_dither;
    int k;
    logic [9:0] sc;
    sc = 10'b0110110001;
    cur_code = make_code(sc);
    k = 1;
    while (cur_code[k] == cur_code[k-1]) k++;
    do_reset(sc, 2'b10, INC_MAX);
    for (int n = 1; n <= 41; n++) begin
      wait_epoch();
      repeat (2*k + 1) @(negedge clk);
      chk("R6", $sformatf("dither period %0d", n), int'(track),
          int'(((n / 20) % 2 == 1) ? bip(cur_code[k-1]) : bip(cur_code[k])));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    inc   = '0;
    sel   = '0;
    mode  = '0;
    t_sequence();
    t_rate();
    t_dither();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule